// File: doc/BRIEF.md
# I2C Register Target with Time-Register Freeze

This block is an I2C target that exposes a small byte-wide register file through a volatile word pointer. The first eight registers mirror a timekeeping counter that runs in the background and feeds the block one byte per update strobe. The remaining registers are plain storage.

A master sets the pointer with a write transaction. It then writes data bytes, or issues a repeated START and reads bytes sequentially. While a transaction is open and the pointer sits on one of the time registers, copying live time bytes into the visible registers is suspended. A master therefore reads a consistent snapshot. The background counter keeps running during the freeze. When the freeze lifts, either on STOP or when the pointer moves past the time registers, all eight visible time registers are refreshed with the latest values in one system clock.

SCL and SDA are taken in raw and synchronised to the system clock. SDA is driven only as an open-drain pull-down enable. Every SDA change is held back a programmable number of cycles after each SCL falling edge, so that the data stays valid across the slow falling edge of SCL.

Top module: `i2c_freeze_regfile`

## Requirements
- R1: After reset, `sda_oe` is 0, `time_hold` is 0 and the word pointer is 0, so a read issued without a pointer write returns register 0 first.
- R2: A target address byte whose upper seven bits equal `DEV_ADDR` (default 7'h68, bit 0 is R/W with 0 = write, 1 = read) is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the following bytes are neither acknowledged nor stored until the next START.
- R3: In a write transaction the first byte after the address loads the pointer. Each following byte is stored at the pointer, is acknowledged, and the pointer increments on that byte's acknowledge clock.
- R4: After a START or repeated START with R/W = 1, the byte at the pointer is sent MSB first. Each master ACK increments the pointer and the next byte follows, until STOP.
- R5: A read transaction with no pointer write first returns the register at the pointer value left by the previous transaction.
- R6: After a master NACK on a read byte, the target releases SDA, ignores clocks until STOP or START, and leaves the pointer unchanged.
- R7: The pointer wraps from the last register (19) to register 0, in both reads and writes.
- R8: While a transaction addressed to this target is open and the pointer is below `CLK_REGS` (8), `time_hold` is 1 and time-counter updates do not change the visible registers 0..7. This holds for both reads and writes.
- R9: The freeze ends on STOP, or when the pointer moves to 8 or above. In that clock all visible time registers take the latest counter values, including any updates made during the freeze.
- R10: When not frozen, an update on `tc_sel`/`tc_byte` with `tc_we` = 1 appears in visible register `tc_sel` on the next clock.
- R11: A change of `sda_oe` caused by an SCL falling edge occurs `SDA_HOLD` + 3 system clocks after that edge reaches `scl_i`, never earlier. SDA is only pulled low and never driven high.
- R12: A word address of 20 or more loads the pointer with 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| tc_we | input | 1 | Time-counter byte update strobe |
| tc_sel | input | $clog2(CLK_REGS) | Index of the updated time byte |
| tc_byte | input | 8 | New time byte value |
| time_hold | output | 1 | 1 while the visible time registers are frozen |

## Verification
The hardest case to reach is a counter update that lands while a sequential read is in the middle of the time registers. The visible bytes must then stay old for the rest of the read. They must become new at the exact moment the pointer leaves register 7 or the STOP arrives. The bench gets there by opening a read at register 1 and pushing updates between bytes on the bus. It keeps reading past register 7 and then re-reads the updated registers in fresh transactions. A second pass leaves the pointer on a time register in a write transaction, pushes updates, and releases with a bare STOP, so that the release path is exercised separately from pointer movement.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WADDR,
    ST_WDATA,
    ST_HOLD8,
    ST_ACK,
    ST_RDATA,
    ST_RHOLD,
    ST_RACK,
    ST_WAIT
  } tgt_state_t;
endpackage

// File: rtl/i2cf_sync.sv
module i2cf_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cf_bus_cond.sv
module i2cf_bus_cond #(
  parameter int HOLD = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall_d
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign start_det = scl & scl_p & sda_p & ~sda;
  assign stop_det  = scl & scl_p & ~sda_p & sda;
  assign scl_rise  = scl & ~scl_p;

  generate
    if (HOLD == 0) begin : g_nohold
      assign scl_fall_d = scl_p & ~scl;
    end else begin : g_hold
      localparam int CW = $clog2(HOLD + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (scl_p & ~scl) cnt <= CW'(HOLD);
        else if (cnt != '0) cnt <= cnt - 1'b1;
      end
      assign scl_fall_d = (cnt == CW'(1));
    end
  endgenerate
endmodule

// File: rtl/i2cf_regfile.sv
module i2cf_regfile #(
  parameter int NUM_REGS = 20,
  parameter int CLK_REGS = 8,
  parameter int AW       = $clog2(NUM_REGS),
  parameter int CSW      = $clog2(CLK_REGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           tc_we,
  input  logic [CSW-1:0] tc_sel,
  input  logic [7:0]     tc_byte,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data
);
  logic [7:0] ureg     [NUM_REGS];
  logic [7:0] live     [CLK_REGS];
  logic [7:0] live_nxt [CLK_REGS];
  logic       hold_q;
  logic       thaw;

  assign thaw = hold_q & ~hold;

  generate
    for (genvar g = 0; g < CLK_REGS; g++) begin : g_live
      assign live_nxt[g] = (tc_we && tc_sel == CSW'(g)) ? tc_byte : live[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      for (int i = 0; i < CLK_REGS; i++) live[i] <= '0;
    end else begin
      hold_q <= hold;
      for (int i = 0; i < CLK_REGS; i++) begin
        if (wr_en && wr_addr == AW'(i)) live[i] <= wr_data;
        else live[i] <= live_nxt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) ureg[i] <= '0;
    end else begin
      for (int i = 0; i < CLK_REGS; i++) begin
        if (wr_en && wr_addr == AW'(i)) ureg[i] <= wr_data;
        else if (thaw) ureg[i] <= live_nxt[i];
        else if (!hold && tc_we && tc_sel == CSW'(i)) ureg[i] <= tc_byte;
      end
      for (int i = CLK_REGS; i < NUM_REGS; i++) begin
        if (wr_en && wr_addr == AW'(i)) ureg[i] <= wr_data;
      end
    end
  end

  assign rd_data = ureg[rd_addr];
endmodule

// File: rtl/i2cf_target.sv
module i2cf_target
  import i2cf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         NUM_REGS = 20,
  parameter int         AW       = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          active,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          in_wait
);
  tgt_state_t state, nxt;
  logic [2:0] bit_cnt;
  logic [6:0] sr;
  logic [6:0] tx;
  logic       give_ack, inc_on_ack, rack_ok;
  logic [7:0] byte_in;
  logic [AW-1:0] ptr_inc;

  assign byte_in = {sr, sda_in};
  assign ptr_inc = (ptr == AW'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;
  assign in_wait = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      nxt        <= ST_IDLE;
      bit_cnt    <= '0;
      sr         <= '0;
      tx         <= '0;
      give_ack   <= 1'b0;
      inc_on_ack <= 1'b0;
      rack_ok    <= 1'b0;
      sda_oe     <= 1'b0;
      ptr        <= '0;
      active     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        active <= 1'b0;
      end else if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              sr      <= byte_in[6:0];
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) begin
                state <= ST_HOLD8;
                if (state == ST_ADDR) begin
                  inc_on_ack <= 1'b0;
                  if (byte_in[7:1] == DEV_ADDR) begin
                    give_ack <= 1'b1;
                    active   <= 1'b1;
                    nxt      <= byte_in[0] ? ST_RDATA : ST_WADDR;
                  end else begin
                    give_ack <= 1'b0;
                    active   <= 1'b0;
                  end
                end else if (state == ST_WADDR) begin
                  give_ack   <= 1'b1;
                  inc_on_ack <= 1'b0;
                  nxt        <= ST_WDATA;
                  ptr        <= (byte_in < 8'(NUM_REGS)) ? byte_in[AW-1:0] : '0;
                end else begin
                  give_ack   <= 1'b1;
                  inc_on_ack <= 1'b1;
                  nxt        <= ST_WDATA;
                  wr_en      <= 1'b1;
                  wr_addr    <= ptr;
                  wr_data    <= byte_in;
                end
              end
            end
          end
          ST_HOLD8: begin
            if (scl_fall) begin
              if (give_ack) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise && inc_on_ack) ptr <= ptr_inc;
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= nxt;
              if (nxt == ST_RDATA) begin
                tx     <= rd_data[6:0];
                sda_oe <= ~rd_data[7];
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) state <= ST_RHOLD;
            end
            if (scl_fall) begin
              sda_oe <= ~tx[6];
              tx     <= {tx[5:0], 1'b0};
            end
          end
          ST_RHOLD: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              rack_ok <= ~sda_in;
              if (!sda_in) ptr <= ptr_inc;
            end
            if (scl_fall) begin
              if (rack_ok) begin
                tx      <= rd_data[6:0];
                sda_oe  <= ~rd_data[7];
                bit_cnt <= '0;
                state   <= ST_RDATA;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_freeze_regfile.sv
module i2c_freeze_regfile #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         NUM_REGS = 20,
  parameter int         CLK_REGS = 8,
  parameter int         SDA_HOLD = 60
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe,
  input  logic                        tc_we,
  input  logic [$clog2(CLK_REGS)-1:0] tc_sel,
  input  logic [7:0]                  tc_byte,
  output logic                        time_hold
);
  localparam int AW  = $clog2(NUM_REGS);
  localparam int CSW = $clog2(CLK_REGS);

  logic [1:0]    synced;
  logic          start_det, stop_det, scl_rise, scl_fall_d;
  logic [AW-1:0] ptr;
  logic          active, in_wait;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data, rd_data;

  i2cf_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(synced)
  );

  i2cf_bus_cond #(.HOLD(SDA_HOLD)) u_cond (
    .clk(clk), .rst(rst), .scl(synced[1]), .sda(synced[0]),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall_d(scl_fall_d)
  );

  i2cf_target #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .AW(AW)) u_tgt (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall_d), .sda_in(synced[0]),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .active(active),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .in_wait(in_wait)
  );

  assign time_hold = active && (ptr < AW'(CLK_REGS));

  i2cf_regfile #(.NUM_REGS(NUM_REGS), .CLK_REGS(CLK_REGS), .AW(AW), .CSW(CSW)) u_rf (
    .clk(clk), .rst(rst), .hold(time_hold), .tc_we(tc_we), .tc_sel(tc_sel),
    .tc_byte(tc_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: rtl/i2cf_chk.sv
module i2cf_chk #(
  parameter int NUM_REGS = 20,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_det,
  input logic          stop_det,
  input logic          scl_rise,
  input logic          scl_fall_d,
  input logic          sda_oe,
  input logic [AW-1:0] ptr,
  input logic          time_hold,
  input logic          in_wait
);
  // R11
  oe_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall_d || start_det || stop_det));

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr < AW'(NUM_REGS));

  // R3
  ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> $past(scl_rise));

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && !time_hold));

  // R2
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> !sda_oe);

  // R9
  thaw_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(time_hold) |-> ($past(stop_det) || $past(scl_rise)));
endmodule

bind i2c_freeze_regfile i2cf_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
  .scl_rise(scl_rise), .scl_fall_d(scl_fall_d), .sda_oe(sda_oe),
  .ptr(ptr), .time_hold(time_hold), .in_wait(in_wait)
);

// File: tb/sim_i2c_freeze_regfile.sv
module sim_i2c_freeze_regfile;
  localparam int         HOLD = 6;
  localparam int         H    = 20;
  localparam logic [6:0] DEV  = 7'h68;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic tc_we = 1'b0;
  logic [2:0] tc_sel = '0;
  logic [7:0] tc_byte = '0;
  logic sda_oe, time_hold;
  wire  sda_bus = m_sda & ~sda_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [16];
  logic [7:0] wbuf [4];

  always #2.5 clk = ~clk;

  i2c_freeze_regfile #(.DEV_ADDR(DEV), .SDA_HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .tc_we(tc_we), .tc_sel(tc_sel), .tc_byte(tc_byte), .time_hold(time_hold)
  );

  // {is_read, pointer, data}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h08, 8'h5A}, {1'b0, 8'h09, 8'hC3}, {1'b0, 8'h0A, 8'h7E},
    {1'b0, 8'h0C, 8'h91}, {1'b1, 8'h08, 8'h5A}, {1'b1, 8'h09, 8'hC3},
    {1'b1, 8'h0A, 8'h7E}, {1'b1, 8'h0C, 8'h91}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw();
    m_scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw();
    m_scl = 1'b1; hw();
    m_sda = 1'b1; hw();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked, output int lat);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw();
      m_scl = 1'b1; hw();
      m_scl = 1'b0;
    end
    m_sda = 1'b1;
    lat = 0;
    for (int k = 0; k < H; k++) begin
      @(negedge clk);
      if (sda_oe && lat == 0) lat = k + 1;
    end
    m_scl = 1'b1;
    repeat (H/2) @(negedge clk);
    acked = (sda_bus == 1'b0);
    repeat (H - H/2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hw();
      m_scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_bus;
      repeat (H - H/2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = ack ? 1'b0 : 1'b1; hw();
    m_scl = 1'b1; hw();
    m_scl = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] p, input int n);
    bit a; int l;
    bus_start();
    put_byte({DEV, 1'b0}, a, l); check("R2 address ack", a, 1);
    put_byte(p, a, l);           check("R3 pointer ack", a, 1);
    for (int j = 0; j < n; j++) begin
      put_byte(wbuf[j], a, l);   check("R3 data ack", a, 1);
    end
    bus_stop();
  endtask

  task automatic read_seq(input bit set_ptr, input logic [7:0] p, input int n);
    bit a; int l;
    bus_start();
    if (set_ptr) begin
      put_byte({DEV, 1'b0}, a, l);
      put_byte(p, a, l);
      bus_start();
    end
    put_byte({DEV, 1'b1}, a, l); check("R4 read address ack", a, 1);
    for (int j = 0; j < n; j++) get_byte(j < n - 1, rbuf[j]);
    bus_stop();
  endtask

  task automatic tc_push(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    tc_we = 1'b1; tc_sel = s; tc_byte = v;
    @(negedge clk);
    tc_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit a; int l; logic [7:0] b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 time_hold after reset", time_hold, 0);

    // R10 updates pass through when not held
    for (int i = 0; i < 8; i++) tc_push(3'(i), 8'h10 + 8'(i));
    @(negedge clk);
    // R1 pointer starts at 0; R4 sequential read
    read_seq(1'b0, 8'h00, 8);
    for (int i = 0; i < 8; i++) check("R1/R4/R10 sequential time read", rbuf[i], 8'h10 + 8'(i));

    // vector table: writes then readbacks (R3)
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][16]) begin
        read_seq(1'b1, VEC[v][15:8], 1);
        check("R3 readback", rbuf[0], VEC[v][7:0]);
      end else begin
        wbuf[0] = VEC[v][7:0];
        do_write(VEC[v][15:8], 1);
      end
    end

    // R3 multi-byte write with pointer auto-increment
    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    do_write(8'h0E, 2);
    read_seq(1'b1, 8'h0E, 2);
    check("R3 incrementing write byte0", rbuf[0], 8'hD1);
    check("R3 incrementing write byte1", rbuf[1], 8'hD2);

    // R6 NACK leaves pointer in place; R5 direct read from last pointer
    read_seq(1'b1, 8'h0A, 1);
    check("R6 first read", rbuf[0], 8'h7E);
    read_seq(1'b0, 8'h00, 1);
    check("R6/R5 repeat after NACK", rbuf[0], 8'h7E);

    // R2 mismatched address ignored; R11 latency measured on a match
    bus_start();
    put_byte({7'h50, 1'b0}, a, l); check("R2 no ack on mismatch", a, 0);
    put_byte(8'h09, a, l);         check("R2 ignored byte no ack", a, 0);
    put_byte(8'hEE, a, l);         check("R2 ignored data no ack", a, 0);
    bus_stop();
    read_seq(1'b1, 8'h09, 1);
    check("R2 register untouched by ignored write", rbuf[0], 8'hC3);
    bus_start();
    put_byte({DEV, 1'b0}, a, l);
    check("R11 ack delayed after SCL fall", l, HOLD + 3);
    bus_stop();

    // R7 wrap in write and read
    wbuf[0] = 8'h66; wbuf[1] = 8'h77;
    do_write(8'h13, 2);
    read_seq(1'b1, 8'h13, 2);
    check("R7 reg 19", rbuf[0], 8'h66);
    check("R7 wrap to reg 0", rbuf[1], 8'h77);

    // R12 out-of-range word address
    wbuf[0] = 8'h3C;
    do_write(8'h1F, 1);
    read_seq(1'b1, 8'h00, 1);
    check("R12 pointer forced to 0", rbuf[0], 8'h3C);

    // R8/R9 freeze during read, release when pointer passes 7
    bus_start();
    put_byte({DEV, 1'b0}, a, l);
    put_byte(8'h01, a, l);
    bus_start();
    put_byte({DEV, 1'b1}, a, l);
    get_byte(1'b1, b); check("R8 first frozen byte", b, 8'h11);
    check("R8 hold during read", time_hold, 1);
    tc_push(3'd1, 8'hA1);
    tc_push(3'd6, 8'hA6);
    for (int i = 2; i < 8; i++) begin
      get_byte(1'b1, b);
      check("R8 frozen value", b, 8'h10 + 8'(i));
    end
    check("R9 hold lifted past reg 7", time_hold, 0);
    get_byte(1'b0, b); check("R4 reg 8 after time regs", b, 8'h5A);
    bus_stop();
    read_seq(1'b1, 8'h06, 1);
    check("R9 released value reg 6", rbuf[0], 8'hA6);
    read_seq(1'b1, 8'h01, 1);
    check("R9 released value reg 1", rbuf[0], 8'hA1);

    // R8/R9 freeze in write transaction, release by STOP
    bus_start();
    put_byte({DEV, 1'b0}, a, l);
    put_byte(8'h02, a, l);
    check("R8 hold during write", time_hold, 1);
    tc_push(3'd2, 8'hB2);
    tc_push(3'd3, 8'hB3);
    bus_stop();
    check("R9 hold lifted by STOP", time_hold, 0);
    read_seq(1'b0, 8'h00, 2);
    check("R5/R9 direct read reg 2", rbuf[0], 8'hB2);
    check("R9 reg 3 refreshed", rbuf[1], 8'hB3);

    // R10 after thaw, plain update
    tc_push(3'd4, 8'hC4);
    read_seq(1'b1, 8'h04, 1);
    check("R10 update while idle", rbuf[0], 8'hC4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule